// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is a synchronous serial master for the Microwire frame format. Software-facing logic pushes 8-bit command bytes into a small transmit queue. Each queued byte starts one half-duplex frame. Frame select drops and the command is shifted out most significant bit first. One idle serial clock follows, and then a response of 4 to 16 bits is shifted in from the slave, also most significant bit first. The received word is right-justified and pushed into a receive queue. The host drains that queue through a read strobe.

The serial clock is made by dividing the system clock. A half-period setting gives the number of system clocks per serial half-period. All serial outputs come from flip-flops. When the block is disabled, the data-out enable is dropped so the pin floats, and no frame starts.

Top module: `uwire_master`

## Requirements
- R1: With the block enabled and no frame in progress, `sclk` is 0, `fs_n` is 1 and `mosi` is 0. After reset both queues are empty and `tx_ovf` is 0.
- R2: A frame starts (`fs_n` falls) only while `en` is 1 and the transmit queue holds a byte. Queued bytes are sent oldest first.
- R3: A frame sends exactly 8 command bits on `mosi`, most significant first, each captured on a rising `sclk` edge. `mosi` never changes while `sclk` is high.
- R4: `miso` is not sampled during the 8 command clocks or during the single idle clock after them. The first response bit is sampled on the 10th rising `sclk` edge of the frame.
- R5: The response length is N = `resp_len` for values 4..16. Values below 4 act as 4 and values above 16 act as 16. `resp_len` is latched when the frame starts. A frame has exactly 9+N rising `sclk` edges.
- R6: Response bits are sampled on rising `sclk`, most significant first. They are stored right-justified in `rx_data` with the upper 16-N bits zero.
- R7: `fs_n` rises one serial period after the last sampling edge, and the word is written into the receive queue at that same edge. Measured in system clocks, `fs_n` stays low for (2*(9+N)+1)*H.
- R8: Each `sclk` half-period lasts H system clocks, where H = `clk_half`, and a value of 0 acts as 1. The first rising `sclk` edge comes H system clocks after `fs_n` falls.
- R9: When `en` is 0, `mosi_oe` is 0 from the next clock, no frame starts, and a frame in progress is abandoned with the idle pin levels.
- R10: Each queue holds 8 words and reports full and empty. A write to a full transmit queue is dropped and sets `tx_ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| clk_half | input | 8 | System clocks per serial half-period (0 acts as 1) |
| resp_len | input | 5 | Response length in bits, clamped to 4..16 |
| tx_wr | input | 1 | Transmit queue write strobe |
| tx_data | input | 8 | Command byte to queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ovf | output | 1 | Sticky flag: a write reached a full transmit queue |
| rx_rd | input | 1 | Receive queue read strobe |
| rx_data | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock |
| fs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps every response length from 4 to 16 against half-periods of 1, 2 and 3, with a different command in each frame. This separates errors in bit counting, in the divider and in frame-length timing. The modelled slave returns a word derived from the command it captured and holds `miso` at 1 outside the response window. Any sampling during the command or the idle clock therefore corrupts the right-justified result, and so does a swapped bit order. Out-of-range lengths (0 and 31) and a zero half-period check the clamping. A burst of nine writes while disabled checks overflow, the disabled state and oldest-first ordering, which shows up in the sequence of received words.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam int CMD_W     = 8;
    localparam int RSP_MIN   = 4;
    localparam int RSP_MAX   = 16;
    localparam int LEN_W     = $clog2(RSP_MAX + 1);
    localparam int BIDX_W    = $clog2(CMD_W + 1 + RSP_MAX);
    localparam int Q_DEPTH   = 8;
    localparam int DIV_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } fsm_e;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [RSP_MAX-1:0] rsp;
        logic [BIDX_W-1:0]  bidx;
        logic [BIDX_W-1:0]  last;
    } frame_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        if (v < LEN_W'(RSP_MIN))      return LEN_W'(RSP_MIN);
        else if (v > LEN_W'(RSP_MAX)) return LEN_W'(RSP_MAX);
        else                          return v;
    endfunction

endpackage

// File: rtl/uwire_fifo.sv
module uwire_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uwire_clkgen.sv
module uwire_clkgen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] half,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] half_eff;

    assign half_eff = (half == '0) ? DW'(1) : half;
    assign tick     = run && (cnt >= half_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uwire_engine.sv
module uwire_engine
    import uwire_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic [CMD_W-1:0]   cmd_in,
    input  logic               cmd_avail,
    input  logic [LEN_W-1:0]   len_cfg,
    input  logic               miso,
    output logic               cmd_pop,
    output logic               run,
    output logic               rsp_push,
    output logic [RSP_MAX-1:0] rsp_word,
    output logic               sclk,
    output logic               fs_n,
    output logic               mosi,
    output logic               mosi_oe
);
    localparam logic [BIDX_W-1:0] BI_CMD  = BIDX_W'(CMD_W);
    localparam logic [BIDX_W-1:0] BI_LAST = BIDX_W'(CMD_W - 1);

    fsm_e   state;
    frame_t fr;

    assign cmd_pop  = (state == ST_IDLE) && en && cmd_avail;
    assign run      = (state != ST_IDLE);
    assign rsp_push = (state == ST_TAIL) && tick;
    assign rsp_word = fr.rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            fr      <= '0;
            sclk    <= 1'b0;
            fs_n    <= 1'b1;
            mosi    <= 1'b0;
            mosi_oe <= 1'b0;
        end else begin
            mosi_oe <= en;
            if (!en) begin
                state <= ST_IDLE;
                sclk  <= 1'b0;
                fs_n  <= 1'b1;
                mosi  <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (cmd_avail) begin
                            fr.cmd  <= cmd_in << 1;
                            fr.rsp  <= '0;
                            fr.bidx <= '0;
                            fr.last <= BI_CMD + BIDX_W'(clamp_len(len_cfg));
                            mosi    <= cmd_in[CMD_W-1];
                            fs_n    <= 1'b0;
                            state   <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (tick) begin
                            if (!sclk) begin
                                sclk <= 1'b1;
                                if (fr.bidx > BI_CMD)
                                    fr.rsp <= {fr.rsp[RSP_MAX-2:0], miso};
                            end else begin
                                sclk   <= 1'b0;
                                mosi   <= (fr.bidx < BI_LAST) ? fr.cmd[CMD_W-1] : 1'b0;
                                fr.cmd <= fr.cmd << 1;
                                if (fr.bidx == fr.last) state   <= ST_TAIL;
                                else                    fr.bidx <= fr.bidx + 1'b1;
                            end
                        end
                    end
                    ST_TAIL: begin
                        if (tick) begin
                            fs_n  <= 1'b1;
                            state <= ST_GAP;
                        end
                    end
                    default: begin
                        if (tick) state <= ST_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uwire_master.sv
module uwire_master
    import uwire_pkg::*;
#(
    parameter int DIV_BITS = DIV_W,
    parameter int DEPTH    = Q_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DIV_BITS-1:0] clk_half,
    input  logic [LEN_W-1:0]    resp_len,
    input  logic                tx_wr,
    input  logic [CMD_W-1:0]    tx_data,
    output logic                tx_full,
    output logic                tx_empty,
    output logic                tx_ovf,
    input  logic                rx_rd,
    output logic [RSP_MAX-1:0]  rx_data,
    output logic                rx_full,
    output logic                rx_empty,
    output logic                sclk,
    output logic                fs_n,
    output logic                mosi,
    output logic                mosi_oe,
    input  logic                miso
);
    logic [CMD_W-1:0]   cmd_q;
    logic               cmd_pop, run, tick, rsp_push;
    logic [RSP_MAX-1:0] rsp_word;

    uwire_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .wr(tx_wr), .wdata(tx_data),
        .rd(cmd_pop), .rdata(cmd_q),
        .full(tx_full), .empty(tx_empty)
    );

    uwire_fifo #(.W(RSP_MAX), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .wr(rsp_push), .wdata(rsp_word),
        .rd(rx_rd), .rdata(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    uwire_clkgen #(.DW(DIV_BITS)) u_div (
        .clk(clk), .rst(rst), .run(run), .half(clk_half), .tick(tick)
    );

    uwire_engine u_eng (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .cmd_in(cmd_q), .cmd_avail(!tx_empty), .len_cfg(resp_len),
        .miso(miso), .cmd_pop(cmd_pop), .run(run),
        .rsp_push(rsp_push), .rsp_word(rsp_word),
        .sclk(sclk), .fs_n(fs_n), .mosi(mosi), .mosi_oe(mosi_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)                    tx_ovf <= 1'b0;
        else if (tx_wr && tx_full)  tx_ovf <= 1'b1;
    end
endmodule

// File: rtl/uwire_master_chk.sv
module uwire_master_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic tx_wr,
    input logic tx_full,
    input logic tx_empty,
    input logic tx_ovf,
    input logic sclk,
    input logic fs_n,
    input logic mosi,
    input logic mosi_oe
);
    p_idle_sclk_r1: assert property (@(posedge clk) disable iff (rst)
        fs_n |-> !sclk);

    p_idle_mosi_r1: assert property (@(posedge clk) disable iff (rst)
        fs_n |-> !mosi);

    p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_n) |-> $past(en && !tx_empty));

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_rise_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !fs_n);

    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mosi_oe);

    p_oe_on_r9: assert property (@(posedge clk) disable iff (rst)
        en |=> mosi_oe);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_full) |=> tx_ovf);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |=> tx_ovf);
endmodule

bind uwire_master uwire_master_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .tx_wr(tx_wr), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_ovf(tx_ovf), .sclk(sclk), .fs_n(fs_n),
    .mosi(mosi), .mosi_oe(mosi_oe)
);

// File: tb/uwire_master_tb.sv
module uwire_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  clk_half = 8'd1;
    logic [4:0]  resp_len = 5'd4;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_rd = 1'b0;
    logic        miso = 1'b1;
    logic        tx_full, tx_empty, tx_ovf, rx_full, rx_empty;
    logic [15:0] rx_data;
    logic        sclk, fs_n, mosi, mosi_oe;

    int n_vec = 0, n_bad = 0;
    int cyc = 0;
    int n_exp = 4;

    // slave-model bookkeeping
    int          k = 0, t_start = 0, t_rise1 = 0, viol = 0, frames_seen = 0;
    int          last_len = 0, last_rises = 0, last_rise1 = 0;
    logic [7:0]  cmd_cap = '0, last_cmd = '0;
    logic        sclk_p = 1'b0, fs_p = 1'b1, mosi_p = 1'b0;

    uwire_master u_dut (
        .clk(clk), .rst(rst), .en(en), .clk_half(clk_half), .resp_len(resp_len),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_ovf(tx_ovf), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
        .rx_empty(rx_empty), .sclk(sclk), .fs_n(fs_n), .mosi(mosi),
        .mosi_oe(mosi_oe), .miso(miso)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] resp_of(input logic [7:0] c, input int n);
        logic [15:0] full_w;
        full_w = {c ^ 8'h5A, ~c};
        return full_w & 16'((32'd1 << n) - 1);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    // slave model, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!fs_n && fs_p) begin
                k = 0; cmd_cap = '0; t_start = cyc; t_rise1 = 0;
            end
            if (!fs_n && sclk && !sclk_p) begin
                k++;
                if (k == 1) t_rise1 = cyc - t_start;
                if (k <= 8) cmd_cap = {cmd_cap[6:0], mosi};
            end
            if (!fs_n && !sclk && sclk_p) begin
                if (k >= 9 && k < 9 + n_exp)
                    miso = resp_of(cmd_cap, n_exp)[n_exp - 1 - (k - 9)];
                else
                    miso = 1'b1;
            end
            if (!fs_n && sclk && sclk_p && (mosi != mosi_p)) viol++;
            if (fs_n && !fs_p) begin
                last_len = cyc - t_start; last_rises = k; last_cmd = cmd_cap;
                last_rise1 = t_rise1; frames_seen++; miso = 1'b1;
            end
        end
        sclk_p = sclk; fs_p = fs_n; mosi_p = mosi;
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] cmd, input logic [4:0] lcfg,
                             input logic [7:0] hcfg);
        int n, h, seen;
        n = (lcfg < 4) ? 4 : (lcfg > 16) ? 16 : int'(lcfg);
        h = (hcfg == 0) ? 1 : int'(hcfg);
        @(negedge clk);
        n_exp = n; resp_len = lcfg; clk_half = hcfg;
        seen = frames_seen;
        push(cmd);
        while (frames_seen == seen) @(negedge clk);
        chk("R3 command bits", int'(last_cmd), int'(cmd));
        chk("R5 rising edges", last_rises, 9 + n);
        chk("R7 frame length", last_len, (2 * (9 + n) + 1) * h);
        chk("R8 first rise offset", last_rise1, h);
        chk("R7 word queued", int'(rx_empty), 0);
        chk("R4,R6 response word", int'(rx_data), int'(resp_of(cmd, n)));
        pop();
        chk("R7 single word", int'(rx_empty), 1);
        // let the post-frame gap expire before reconfiguring
        repeat (2 * h + 2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset and idle state
        chk("R1 sclk idle", int'(sclk), 0);
        chk("R1 fs_n idle", int'(fs_n), 1);
        chk("R1 mosi idle", int'(mosi), 0);
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 tx_ovf", int'(tx_ovf), 0);
        chk("R9 oe when enabled", int'(mosi_oe), 1);

        // R5 R6 R7 R8 sweep: every length against three half-periods
        for (int h = 1; h <= 3; h++) begin
            for (int l = 4; l <= 16; l++) begin
                run_frame(8'((l * 29 + h * 71) ^ 8'h96), 5'(l), 8'(h));
            end
        end
        // R5 clamping and R8 zero divider
        run_frame(8'hC3, 5'd0, 8'd2);
        run_frame(8'h3C, 5'd31, 8'd1);
        run_frame(8'hFF, 5'd9, 8'd0);
        run_frame(8'h00, 5'd16, 8'd1);
        chk("R3 mosi stable while sclk high", viol, 0);
        chk("R1 idle after frames", int'(fs_n), 1);

        // R9 and R10: disabled block, overfilled queue
        @(negedge clk);
        en = 1'b0; n_exp = 4; resp_len = 5'd4; clk_half = 8'd1;
        repeat (2) @(negedge clk);
        chk("R9 oe released", int'(mosi_oe), 0);
        begin
            int seen0;
            seen0 = frames_seen;
            for (int i = 0; i < 9; i++) push(8'(8'hA0 + i));
            chk("R10 tx_full", int'(tx_full), 1);
            chk("R10 tx_ovf set", int'(tx_ovf), 1);
            repeat (100) @(negedge clk);
            chk("R9 no frame while disabled", frames_seen - seen0, 0);
            chk("R9 fs_n held", int'(fs_n), 1);
            en = 1'b1;
            while (frames_seen != seen0 + 8) @(negedge clk);
            repeat (6) @(negedge clk);
            chk("R10 rx_full", int'(rx_full), 1);
            chk("R10 tx drained", int'(tx_empty), 1);
            chk("R10 tx_ovf sticky", int'(tx_ovf), 1);
            for (int i = 0; i < 8; i++) begin
                chk("R2 oldest first", int'(rx_data), int'(resp_of(8'(8'hA0 + i), 4)));
                pop();
            end
            chk("R10 rx empty after drain", int'(rx_empty), 1);
            repeat (50) @(negedge clk);
            chk("R10 dropped byte never sent", frames_seen - seen0, 8);
        end
        summary();
    end
endmodule